// File: doc/BRIEF.md
# Word-to-Byte Video Output Unpacker

This block sits between a word-wide output FIFO and an 8-bit video byte port. It takes one 32-bit word at a time, together with an end-of-record flag and a count of valid bytes. It then presents the valid bytes one per transfer on the byte port, starting from the least significant byte. The port uses an active-low request and acknowledge handshake: the block pulls request low while it holds a byte, and the receiver pulls acknowledge low to take it.

When a record ends partway through a word, the unused upper bytes of that word are filler. They never appear on the byte port. The final real byte of a record carries an active-low end-of-record marker. A mode input mirrors the bit order of every byte presented. An enable input decides whether words are drawn into this port at all. While it is low, the words stay on the word path.

Control is a two-state machine. `ST_EMPTY` means no word is held, and `ST_PRESENT` means a word is held and a byte is on offer. It has four transitions:
- **FETCH**: `ST_EMPTY` to `ST_PRESENT`, taken when a word is accepted.
- **ADVANCE**: `ST_PRESENT` to itself, taken when a byte that is not the word's last is accepted. The lane index moves up by one.
- **CHAIN**: `ST_PRESENT` to itself. The last byte is accepted and a new word is loaded in the same cycle.
- **DRAIN**: `ST_PRESENT` to `ST_EMPTY`. The last byte is accepted and no new word is loaded.

Top module: `vout_unpacker`

## Requirements
- R1: After reset, `vo_req_n` and `vo_eor_n` are high.
- R2: A byte is transferred on a rising clock edge where `vo_req_n` and `vo_ack_n` are both low. While `vo_req_n` is low and `vo_ack_n` is high, `vo_data` and `vo_eor_n` hold their values.
- R3: The bytes of a word appear in lane order starting from `in_word[7:0]`, then `in_word[15:8]`, and so on.
- R4: A word with `in_eor`=1 yields `in_cnt` bytes when `in_cnt` is 1, 2 or 3, and yields 4 bytes when `in_cnt` is 0. A word with `in_eor`=0 always yields 4 bytes, whatever `in_cnt` is. Pad lanes are never presented.
- R5: `vo_eor_n` is low exactly while the final valid byte of a word with `in_eor`=1 is on offer, and is high otherwise.
- R6: With `rev_mode`=1, bit i of `vo_data` equals bit 7-i of the selected byte. With `rev_mode`=0, the byte passes through unchanged.
- R7: `in_ready` is high only when no word is held, or when the last valid byte is being accepted in that cycle. A word offered at that moment is loaded with no request gap: its first byte is on offer in the next cycle.
- R8: While `port_en` is low, `in_ready` stays low and no word is taken.
- R9: `vo_req_n` goes low in the cycle after a word is accepted. It returns high after the last byte is accepted if no new word was loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Route words to the byte port |
| rev_mode | input | 1 | Mirror bit order of each output byte |
| in_valid | input | 1 | Word side has a word available |
| in_ready | output | 1 | Block accepts the offered word this cycle |
| in_word | input | 32 | Word data, lane 0 in bits 7:0 |
| in_eor | input | 1 | Word closes a record |
| in_cnt | input | 2 | Valid bytes in a closing word (0 = all four) |
| vo_req_n | output | 1 | Active-low: byte on offer |
| vo_ack_n | input | 1 | Active-low: receiver takes the byte |
| vo_data | output | 8 | Byte on offer |
| vo_eor_n | output | 1 | Active-low: byte on offer ends the record |

## Verification
Two functions can fall in the same cycle: accepting the last byte of a word, possibly with the end-of-record marker, and loading the next word. This is the CHAIN transition. The bench provokes it by holding acknowledge low and keeping a word offered continuously. It also runs throttled passes where acknowledge and word availability drop out on fixed patterns, so the chain is met both with and without stalls. It judges the result by comparing every transferred byte and marker against an expected stream computed from the word table, and by counting request-high cycles inside the unthrottled stream, which must be zero.

// File: rtl/vout_pkg.sv
package vout_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic {
        ST_EMPTY   = 1'b0,
        ST_PRESENT = 1'b1
    } vo_state_e;
endpackage

// File: rtl/vout_ctrl.sv
module vout_ctrl
    import vout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic in_valid,
    input  logic vo_ack_n,
    input  logic at_last,
    output logic in_ready,
    output logic load,
    output logic step,
    output logic vo_req_n
);
    vo_state_e state_q, state_d;
    logic      fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // outputs and next state
    always_comb begin
        vo_req_n = 1'b1;
        in_ready = 1'b0;
        fire     = 1'b0;
        step     = 1'b0;
        load     = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = port_en;
                load     = in_ready & in_valid;
                if (load) state_d = ST_PRESENT;              // FETCH
            end
            ST_PRESENT: begin
                vo_req_n = 1'b0;
                fire     = ~vo_ack_n;
                step     = fire & ~at_last;                   // ADVANCE
                in_ready = port_en & fire & at_last;
                load     = in_ready & in_valid;               // CHAIN
                if (fire && at_last && !load) state_d = ST_EMPTY; // DRAIN
            end
            default: state_d = ST_EMPTY;
        endcase
    end
endmodule

// File: rtl/vout_hold.sv
module vout_hold
    import vout_pkg::*;
#(
    parameter int W_WORD = WORD_W,
    parameter int W_BYTE = BYTE_W,
    localparam int NLANE = W_WORD / W_BYTE,
    localparam int IDX_W = $clog2(NLANE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [W_WORD-1:0] in_word,
    input  logic              in_eor,
    input  logic [IDX_W-1:0]  in_cnt,
    output logic [W_BYTE-1:0] cur_byte,
    output logic              at_last,
    output logic              eor_here
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NLANE - 1);

    logic [W_WORD-1:0] word_q;
    logic [IDX_W-1:0]  idx_q, last_q, last_d;
    logic              eor_q;
    logic [W_BYTE-1:0] lanes [NLANE];

    always_comb begin
        if (in_eor && in_cnt != '0) last_d = in_cnt - 1'b1;
        else                         last_d = TOP_IDX;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
            eor_q  <= 1'b0;
        end else if (load) begin
            word_q <= in_word;
            idx_q  <= '0;
            last_q <= last_d;
            eor_q  <= in_eor;
        end else if (step) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lanes[g] = word_q[g*W_BYTE +: W_BYTE];
    end

    assign cur_byte = lanes[idx_q];
    assign at_last  = (idx_q == last_q);
    assign eor_here = eor_q & at_last;
endmodule

// File: rtl/vout_lane.sv
module vout_lane
    import vout_pkg::*;
#(
    parameter int W_BYTE = BYTE_W
) (
    input  logic              rev_mode,
    input  logic              present_n,
    input  logic              eor_here,
    input  logic [W_BYTE-1:0] cur_byte,
    output logic [W_BYTE-1:0] vo_data,
    output logic              vo_eor_n
);
    logic [W_BYTE-1:0] mirrored;

    for (genvar b = 0; b < W_BYTE; b++) begin : g_mirror
        assign mirrored[b] = cur_byte[W_BYTE-1-b];
    end

    assign vo_data  = rev_mode ? mirrored : cur_byte;
    assign vo_eor_n = ~(eor_here & ~present_n);
endmodule

// File: rtl/vout_unpacker.sv
module vout_unpacker
    import vout_pkg::*;
#(
    parameter int W_WORD = WORD_W,
    parameter int W_BYTE = BYTE_W,
    localparam int NLANE = W_WORD / W_BYTE,
    localparam int IDX_W = $clog2(NLANE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              rev_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [W_WORD-1:0] in_word,
    input  logic              in_eor,
    input  logic [IDX_W-1:0]  in_cnt,
    output logic              vo_req_n,
    input  logic              vo_ack_n,
    output logic [W_BYTE-1:0] vo_data,
    output logic              vo_eor_n
);
    logic              load, step, at_last, eor_here;
    logic [W_BYTE-1:0] cur_byte;

    vout_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_en  (port_en),
        .in_valid (in_valid),
        .vo_ack_n (vo_ack_n),
        .at_last  (at_last),
        .in_ready (in_ready),
        .load     (load),
        .step     (step),
        .vo_req_n (vo_req_n)
    );

    vout_hold #(.W_WORD(W_WORD), .W_BYTE(W_BYTE)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .in_word  (in_word),
        .in_eor   (in_eor),
        .in_cnt   (in_cnt),
        .cur_byte (cur_byte),
        .at_last  (at_last),
        .eor_here (eor_here)
    );

    vout_lane #(.W_BYTE(W_BYTE)) u_lane (
        .rev_mode  (rev_mode),
        .present_n (vo_req_n),
        .eor_here  (eor_here),
        .cur_byte  (cur_byte),
        .vo_data   (vo_data),
        .vo_eor_n  (vo_eor_n)
    );
endmodule

// File: rtl/vout_unpacker_chk.sv
module vout_unpacker_chk #(
    parameter int W_BYTE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic              in_valid,
    input logic              in_ready,
    input logic              vo_req_n,
    input logic              vo_ack_n,
    input logic [W_BYTE-1:0] vo_data,
    input logic              vo_eor_n
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!vo_req_n && vo_ack_n) |=> (!vo_req_n && $stable(vo_data) && $stable(vo_eor_n)));

    p_eor_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vo_eor_n |-> !vo_req_n);

    p_eor_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!vo_req_n && !vo_ack_n && !vo_eor_n && !(in_valid && in_ready)) |=> vo_req_n);

    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vo_req_n && vo_ack_n) |-> !in_ready);

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> !in_ready);

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !vo_req_n);
endmodule

bind vout_unpacker vout_unpacker_chk #(.W_BYTE(W_BYTE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .vo_req_n (vo_req_n),
    .vo_ack_n (vo_ack_n),
    .vo_data  (vo_data),
    .vo_eor_n (vo_eor_n)
);

// File: tb/tb_vout_unpacker.sv
module tb_vout_unpacker;
    localparam int NVEC = 8;
    // {eor, cnt[1:0], word[31:0]}
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b0, 2'd2, 32'h44332211},
        {1'b1, 2'd1, 32'hAABBCC01},
        {1'b1, 2'd2, 32'h99887766},
        {1'b1, 2'd3, 32'h0F1E2D3C},
        {1'b1, 2'd0, 32'hDEADBEEF},
        {1'b0, 2'd0, 32'h80402010},
        {1'b0, 2'd1, 32'h01020304},
        {1'b1, 2'd2, 32'h5A5AA5C3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic        rev_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        in_eor = 1'b0;
    logic [1:0]  in_cnt = '0;
    logic        vo_req_n;
    logic        vo_ack_n = 1'b1;
    logic [7:0]  vo_data;
    logic        vo_eor_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vout_unpacker dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .rev_mode(rev_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .in_eor(in_eor), .in_cnt(in_cnt), .vo_req_n(vo_req_n),
        .vo_ack_n(vo_ack_n), .vo_data(vo_data), .vo_eor_n(vo_eor_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input int w);
        if (VEC[w][34] && VEC[w][33:32] != 2'd0) return int'(VEC[w][33:32]);
        return 4;
    endfunction

    function automatic logic [7:0] exp_byte(input int w, input int b, input bit rv);
        logic [7:0] raw, m;
        raw = VEC[w][b*8 +: 8];
        for (int i = 0; i < 8; i++) m[i] = raw[7-i];
        return rv ? m : raw;
    endfunction

    // mode 0: throttled ack and valid; mode 1: continuous
    task automatic run_stream(input bit rv, input bit cont, input string tag);
        int p = 0, cw = 0, cb = 0, cyc = 0, total = 0, expect_total = 0, gaps = 0;
        bit started = 0;
        rev_mode = rv;
        for (int w = 0; w < NVEC; w++) expect_total += nbytes(w);
        while (cw < NVEC && cyc < 2000) begin
            @(negedge clk);
            in_valid = (p < NVEC) && (cont || (cyc % 7) != 2);
            if (p < NVEC) begin
                in_eor  = VEC[p][34];
                in_cnt  = VEC[p][33:32];
                in_word = VEC[p][31:0];
            end
            vo_ack_n = cont ? 1'b0 : ((cyc % 5) == 3);
            #1;
            if (started && vo_req_n) gaps++;
            if (in_valid && in_ready) p++;
            if (!vo_req_n && !vo_ack_n) begin
                started = 1;
                total++;
                // R3 lane order, R4 pad skipping, R6 mirroring
                check({tag, " data R3/R4/R6"}, int'(vo_data), int'(exp_byte(cw, cb, rv)));
                // R5 end-of-record on final valid byte only
                check({tag, " eor R5"}, int'(vo_eor_n),
                      (VEC[cw][34] && cb == nbytes(cw) - 1) ? 0 : 1);
                cb++;
                if (cb == nbytes(cw)) begin cb = 0; cw++; end
            end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        vo_ack_n = 1'b1;
        #1;
        check({tag, " byte count R4"}, total, expect_total);
        if (cont) check({tag, " no request gap R7"}, gaps, 0);
        // R9: request released after final byte with no new word
        check({tag, " idle req R9"}, int'(vo_req_n), 1);
        check({tag, " idle eor R5"}, int'(vo_eor_n), 1);
    endtask

    initial begin
        #1;
        check("reset req R1", int'(vo_req_n), 1);
        check("reset eor R1", int'(vo_eor_n), 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("post-reset req R1", int'(vo_req_n), 1);

        // R8: disabled port takes no word
        in_valid = 1'b1;
        in_word  = 32'h12345678;
        in_eor   = 1'b1;
        in_cnt   = 2'd1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            check("disabled ready R8", int'(in_ready), 0);
        end
        check("disabled no offer R8", int'(vo_req_n), 1);
        in_valid = 1'b0;

        port_en = 1'b1;
        @(negedge clk); #1;
        check("enabled empty ready R7", int'(in_ready), 1);

        // R2: single word with stalled ack holds its byte
        in_valid = 1'b1; in_word = 32'hCAFE00A7; in_eor = 1'b1; in_cnt = 2'd1;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check("offer after load R9", int'(vo_req_n), 0);
        check("first byte R3", int'(vo_data), 32'hA7);
        check("single-byte record eor R5", int'(vo_eor_n), 0);
        check("busy not ready R7", int'(in_ready), 0);
        repeat (3) @(negedge clk);
        #1;
        check("stall holds byte R2", int'(vo_data), 32'hA7);
        check("stall holds req R2", int'(vo_req_n), 0);
        @(negedge clk); vo_ack_n = 1'b0;
        @(negedge clk); vo_ack_n = 1'b1; #1;
        check("drain after accept R9", int'(vo_req_n), 1);

        run_stream(1'b0, 1'b0, "plain");
        run_stream(1'b1, 1'b0, "mirror");
        run_stream(1'b0, 1'b1, "chain");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule